// File: doc/BRIEF.md
# Functional-Unit Scoreboard for Out-of-Order Completion

This block is the central control for a set of functional units that have long and varying latencies and share one register file of eight registers. A decoupled fetch stage hands it one decoded instruction per cycle. Each instruction names a unit, a destination register, two source registers and a tag. The block steps every instruction through five states in order: waiting to issue, waiting for operands, executing, finished, and retired. It grants issue, operand reads and result writes. The units report the end of execution on their own done lines.

The block holds one instruction in the waiting-to-issue slot. While that instruction cannot leave the slot, the block asserts a stall to fetch. For each unit it records the held tag, the destination and source registers, a wait/ready/read status per source, and the unit that will produce each source. For each register it records which unit has claimed it for writing. No arithmetic is done here.

Top module: `ooo_scoreboard`

## Requirements
- R1: While reset is held, and at the first cycle after it, the block asserts no issue, no read grant, no write grant and no fetch stall.
- R2: An instruction issues only when its named unit holds no instruction. A second instruction for a busy unit issues only after that unit's result has been written.
- R3: An instruction does not issue while another issued instruction has claimed the same destination register. While the held instruction cannot issue, fetch_stall is high, and the held instruction stays unchanged until it issues.
- R4: A unit receives its read grant only when none of its sources is waiting for a producing unit. A source that waits on a unit becomes ready on the edge where that unit's result is written, so the read grant comes at the earliest one cycle after that write.
- R5: A done pulse has an effect only while its unit is executing. A pulse for an idle unit, or for a unit waiting for operands, creates no write grant.
- R6: A finished unit does not write its result while another unit waiting for operands still has a ready but unread source equal to that destination register. The write follows that unit's read grant.
- R7: At most one result is written per cycle. When several finished units are eligible, the lowest-numbered unit writes first and the next one writes in the following cycle.
- R8: A result write reports the unit, the destination register and the tag. The write releases the register claim and frees the unit.
- R9: A read grant lasts exactly one cycle per instruction. After it, both sources count as read, so they no longer hold back any writer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A decoded instruction is offered |
| in_unit | input | UW | Functional unit the instruction needs |
| in_dst | input | 3 | Destination register |
| in_src1 | input | 3 | First source register |
| in_src2 | input | 3 | Second source register |
| in_tag | input | TAG_W | Instruction identifier |
| fetch_stall | output | 1 | Held instruction cannot issue; offer is not taken |
| iss_valid | output | 1 | Held instruction issues at this edge |
| iss_unit | output | UW | Unit receiving the issue |
| iss_tag | output | TAG_W | Tag of the issuing instruction |
| rd_grant | output | NUM_UNITS | Per unit: read operands now and start executing |
| unit_done | input | NUM_UNITS | Per unit: execution has finished |
| wb_valid | output | 1 | A result is written at this edge |
| wb_unit | output | UW | Unit writing the result |
| wb_reg | output | 3 | Register being written |
| wb_tag | output | TAG_W | Tag of the retiring instruction |

## Verification
The bench targets the three hazard gates one at a time. In the dependent-read case, a design that misses the producer would grant the read before the producer writes. In the shared-destination case, a design that ignores the register claim would issue the second writer early and let it retire first. In the anti-dependence case, a design without the hold would write a fast result while a slower, earlier reader still has not read the old value; the bench checks that the write comes after that reader's grant.

The bench also injects done pulses into idle units and into units still waiting for operands. A design that honours them would retire results out of turn. Two units finishing in the same cycle show whether the write port goes to the lowest index first and then to the next unit one cycle later.

// File: rtl/ooo_scoreboard.sv
module ooo_scoreboard #(
  parameter int NUM_UNITS = 4,
  parameter int TAG_W     = 8,
  parameter int REG_N     = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [$clog2(NUM_UNITS)-1:0] in_unit,
  input  logic [$clog2(REG_N)-1:0]     in_dst,
  input  logic [$clog2(REG_N)-1:0]     in_src1,
  input  logic [$clog2(REG_N)-1:0]     in_src2,
  input  logic [TAG_W-1:0]      in_tag,
  output logic                  fetch_stall,
  output logic                  iss_valid,
  output logic [$clog2(NUM_UNITS)-1:0] iss_unit,
  output logic [TAG_W-1:0]      iss_tag,
  output logic [NUM_UNITS-1:0]  rd_grant,
  input  logic [NUM_UNITS-1:0]  unit_done,
  output logic                  wb_valid,
  output logic [$clog2(NUM_UNITS)-1:0] wb_unit,
  output logic [$clog2(REG_N)-1:0]     wb_reg,
  output logic [TAG_W-1:0]      wb_tag
);
  localparam int UW = $clog2(NUM_UNITS);
  localparam int RW = $clog2(REG_N);

  typedef enum logic [1:0] {U_IDLE, U_OPS, U_EXEC, U_FIN} ust_t;
  typedef enum logic [1:0] {S_WAIT, S_RDY, S_USED} sst_t;

  ust_t              ust  [NUM_UNITS];
  sst_t              st1  [NUM_UNITS];
  sst_t              st2  [NUM_UNITS];
  logic [TAG_W-1:0]  utag [NUM_UNITS];
  logic [RW-1:0]     udst [NUM_UNITS];
  logic [RW-1:0]     us1  [NUM_UNITS];
  logic [RW-1:0]     us2  [NUM_UNITS];
  logic [UW-1:0]     pr1  [NUM_UNITS];
  logic [UW-1:0]     pr2  [NUM_UNITS];

  logic              claim_v [REG_N];
  logic [UW-1:0]     claim_u [REG_N];

  logic              hold_v;
  logic [UW-1:0]     hold_unit;
  logic [RW-1:0]     hold_dst, hold_s1, hold_s2;
  logic [TAG_W-1:0]  hold_tag;

  logic                 can_issue, take_in;
  logic [NUM_UNITS-1:0] war_hold, wr_elig, wgnt;
  logic [UW-1:0]        wsel;
  logic                 s1_waits, s2_waits;

  assign can_issue   = hold_v && (ust[hold_unit] == U_IDLE) && !claim_v[hold_dst];
  assign fetch_stall = hold_v && !can_issue;
  assign take_in     = in_valid && !fetch_stall;
  assign iss_valid   = can_issue;
  assign iss_unit    = hold_unit;
  assign iss_tag     = hold_tag;

  always_comb begin
    for (int u = 0; u < NUM_UNITS; u++)
      rd_grant[u] = (ust[u] == U_OPS) && (st1[u] != S_WAIT) && (st2[u] != S_WAIT);
  end

  always_comb begin
    for (int u = 0; u < NUM_UNITS; u++) begin
      war_hold[u] = 1'b0;
      for (int v = 0; v < NUM_UNITS; v++)
        if (v != u && ust[v] == U_OPS &&
            ((st1[v] == S_RDY && us1[v] == udst[u]) ||
             (st2[v] == S_RDY && us2[v] == udst[u])))
          war_hold[u] = 1'b1;
      wr_elig[u] = (ust[u] == U_FIN) && !war_hold[u];
    end
  end

  always_comb begin
    wgnt = '0;
    wsel = '0;
    for (int u = 0; u < NUM_UNITS; u++)
      if (wr_elig[u] && wgnt == '0) begin
        wgnt[u] = 1'b1;
        wsel    = UW'(u);
      end
  end

  assign wb_valid = |wgnt;
  assign wb_unit  = wsel;
  assign wb_reg   = udst[wsel];
  assign wb_tag   = utag[wsel];

  assign s1_waits = claim_v[hold_s1] && !(wb_valid && claim_u[hold_s1] == wsel);
  assign s2_waits = claim_v[hold_s2] && !(wb_valid && claim_u[hold_s2] == wsel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v    <= 1'b0;
      hold_unit <= '0;
      hold_dst  <= '0;
      hold_s1   <= '0;
      hold_s2   <= '0;
      hold_tag  <= '0;
    end else begin
      if (iss_valid) hold_v <= 1'b0;
      if (take_in) begin
        hold_v    <= 1'b1;
        hold_unit <= in_unit;
        hold_dst  <= in_dst;
        hold_s1   <= in_src1;
        hold_s2   <= in_src2;
        hold_tag  <= in_tag;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < REG_N; r++) begin
        claim_v[r] <= 1'b0;
        claim_u[r] <= '0;
      end
    end else begin
      if (wb_valid) claim_v[wb_reg] <= 1'b0;
      if (iss_valid) begin
        claim_v[hold_dst] <= 1'b1;
        claim_u[hold_dst] <= hold_unit;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int u = 0; u < NUM_UNITS; u++) begin
        ust[u]  <= U_IDLE;
        st1[u]  <= S_USED;
        st2[u]  <= S_USED;
        utag[u] <= '0;
        udst[u] <= '0;
        us1[u]  <= '0;
        us2[u]  <= '0;
        pr1[u]  <= '0;
        pr2[u]  <= '0;
      end
    end else begin
      for (int u = 0; u < NUM_UNITS; u++) begin
        case (ust[u])
          U_IDLE:
            if (iss_valid && hold_unit == UW'(u)) begin
              ust[u]  <= U_OPS;
              utag[u] <= hold_tag;
              udst[u] <= hold_dst;
              us1[u]  <= hold_s1;
              us2[u]  <= hold_s2;
              pr1[u]  <= claim_u[hold_s1];
              pr2[u]  <= claim_u[hold_s2];
              st1[u]  <= s1_waits ? S_WAIT : S_RDY;
              st2[u]  <= s2_waits ? S_WAIT : S_RDY;
            end
          U_OPS:
            if (rd_grant[u]) begin
              ust[u] <= U_EXEC;
              st1[u] <= S_USED;
              st2[u] <= S_USED;
            end else if (wb_valid) begin
              if (st1[u] == S_WAIT && pr1[u] == wsel) st1[u] <= S_RDY;
              if (st2[u] == S_WAIT && pr2[u] == wsel) st2[u] <= S_RDY;
            end
          U_EXEC:
            if (unit_done[u]) ust[u] <= U_FIN;
          default:
            if (wgnt[u]) ust[u] <= U_IDLE;
        endcase
      end
    end
  end

  // R7
  one_writer_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(wgnt));

  // R8
  wb_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (claim_v[wb_reg] && claim_u[wb_reg] == wb_unit));

  // R8
  wb_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> (ust[$past(wb_unit)] == U_IDLE));

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stall |=> (hold_v && $stable(hold_tag) && $stable(hold_dst)));

  // R2
  issue_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |=> (ust[$past(iss_unit)] == U_OPS));

  genvar g;
  generate
    for (g = 0; g < NUM_UNITS; g++) begin : g_unit_chk
      // R9
      rd_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_grant[g] |=> !rd_grant[g]);
      // R5
      done_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ust[g] == U_IDLE || ust[g] == U_OPS) |=> (ust[g] != U_FIN));
    end
  endgenerate
endmodule

// File: tb/test_ooo_scoreboard.sv
module test_ooo_scoreboard;
  localparam int CLK_PERIOD = 10;
  localparam int NU = 4;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] in_unit = '0;
  logic [2:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic [TW-1:0] in_tag = '0;
  logic fetch_stall, iss_valid, wb_valid;
  logic [1:0] iss_unit, wb_unit;
  logic [TW-1:0] iss_tag, wb_tag;
  logic [NU-1:0] rd_grant, unit_done, cnt_done, extra_done;
  logic [2:0] wb_reg;

  ooo_scoreboard #(.NUM_UNITS(NU), .TAG_W(TW), .REG_N(8)) i_ooo_scoreboard (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_unit(in_unit),
    .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2), .in_tag(in_tag),
    .fetch_stall(fetch_stall), .iss_valid(iss_valid), .iss_unit(iss_unit),
    .iss_tag(iss_tag), .rd_grant(rd_grant), .unit_done(unit_done),
    .wb_valid(wb_valid), .wb_unit(wb_unit), .wb_reg(wb_reg), .wb_tag(wb_tag));

  always #(CLK_PERIOD/2) clk = ~clk;

  assign unit_done = cnt_done | extra_done;

  int n_cmp = 0, n_bad = 0, cyc = 0, stall_seen = 0;
  int lat [NU];
  int cnt [NU];
  logic [TW-1:0] owner [NU];
  int iss_cyc [256];
  int rd_cyc [256];
  int wb_cyc [256];
  logic [TW-1:0] q_tag [$];
  logic [2:0] q_reg [$];
  logic [1:0] q_unit [$];
  string q_req [$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_wb(input int tag, input int rg, input int un, input string req);
    q_tag.push_back(TW'(tag));
    q_reg.push_back(3'(rg));
    q_unit.push_back(2'(un));
    q_req.push_back(req);
  endtask

  task automatic send(input int un, input int d, input int s1, input int s2, input int tag);
    in_valid = 1'b1;
    in_unit = 2'(un);
    in_dst = 3'(d);
    in_src1 = 3'(s1);
    in_src2 = 3'(s2);
    in_tag = TW'(tag);
    while (fetch_stall) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (q_tag.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      for (int u = 0; u < NU; u++) begin
        cnt_done[u] = 1'b0;
        if (cnt[u] > 0) begin
          cnt[u] = cnt[u] - 1;
          if (cnt[u] == 0) cnt_done[u] = 1'b1;
        end
      end
      if (fetch_stall) stall_seen++;
      if (iss_valid) begin
        owner[iss_unit] = iss_tag;
        iss_cyc[iss_tag] = cyc;
      end
      for (int u = 0; u < NU; u++)
        if (rd_grant[u]) begin
          rd_cyc[owner[u]] = cyc;
          cnt[u] = lat[u];
        end
      if (wb_valid) begin
        wb_cyc[wb_tag] = cyc;
        if (q_tag.size() == 0) begin
          chk(1'b0, "R5 unexpected write", int'(wb_tag), -1);
        end else begin
          string rq;
          logic [TW-1:0] et;
          logic [2:0] er;
          logic [1:0] eu;
          et = q_tag.pop_front();
          er = q_reg.pop_front();
          eu = q_unit.pop_front();
          rq = q_req.pop_front();
          chk(wb_tag == et, {rq, " tag"}, int'(wb_tag), int'(et));
          chk(wb_reg == er, "R8 reg", int'(wb_reg), int'(er));
          chk(wb_unit == eu, "R8 unit", int'(wb_unit), int'(eu));
        end
      end
    end
  end

  initial begin
    for (int u = 0; u < NU; u++) begin
      lat[u] = 1;
      cnt[u] = 0;
      owner[u] = '0;
    end
    cnt_done = '0;
    extra_done = '0;
    repeat (3) @(negedge clk);
    chk(fetch_stall == 1'b0, "R1 stall", int'(fetch_stall), 0);
    chk(iss_valid == 1'b0, "R1 issue", int'(iss_valid), 0);
    chk(rd_grant == '0, "R1 read", int'(rd_grant), 0);
    chk(wb_valid == 1'b0, "R1 write", int'(wb_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fetch_stall == 1'b0 && wb_valid == 1'b0, "R1 after release", int'(wb_valid), 0);

    // independent units, fast one retires first
    lat[0] = 5; lat[1] = 1;
    expect_wb(2, 4, 1, "R8");
    expect_wb(1, 1, 0, "R8");
    send(0, 1, 2, 3, 1);
    send(1, 4, 5, 6, 2);
    drain();

    // R4 RAW, plus R5 done pulse on a unit still waiting for operands
    lat[0] = 8; lat[1] = 1;
    expect_wb(3, 1, 0, "R4");
    expect_wb(4, 2, 1, "R4");
    send(0, 1, 0, 0, 3);
    send(1, 2, 1, 3, 4);
    @(negedge clk);
    extra_done[1] = 1'b1;
    @(negedge clk);
    extra_done[1] = 1'b0;
    drain();
    chk(rd_cyc[4] == wb_cyc[3] + 1, "R4 read after producer", rd_cyc[4], wb_cyc[3] + 1);

    // R3 WAW
    lat[0] = 8; lat[1] = 1;
    stall_seen = 0;
    expect_wb(5, 3, 0, "R3");
    expect_wb(6, 3, 1, "R3");
    send(0, 3, 0, 0, 5);
    send(1, 3, 0, 0, 6);
    drain();
    chk(iss_cyc[6] > wb_cyc[5], "R3 issue after claim release", iss_cyc[6], wb_cyc[5] + 1);
    chk(stall_seen > 0, "R3 stall seen", stall_seen, 1);

    // R2 structural
    lat[2] = 6;
    expect_wb(7, 4, 2, "R2");
    expect_wb(8, 5, 2, "R2");
    send(2, 4, 0, 0, 7);
    send(2, 5, 0, 0, 8);
    drain();
    chk(iss_cyc[8] > wb_cyc[7], "R2 issue after unit free", iss_cyc[8], wb_cyc[7] + 1);

    // R6 WAR
    lat[0] = 10; lat[1] = 3; lat[2] = 1;
    expect_wb(10, 1, 0, "R6");
    expect_wb(12, 2, 2, "R6");
    expect_wb(11, 6, 1, "R6");
    send(0, 1, 0, 0, 10);
    send(1, 6, 1, 2, 11);
    send(2, 2, 3, 3, 12);
    drain();
    chk(wb_cyc[12] > rd_cyc[11], "R6 write after reader", wb_cyc[12], rd_cyc[11] + 1);
    chk(rd_cyc[11] == wb_cyc[10] + 1, "R9 read once after producer", rd_cyc[11], wb_cyc[10] + 1);

    // R7 priority
    lat[1] = 3; lat[3] = 2;
    expect_wb(20, 5, 1, "R7");
    expect_wb(21, 7, 3, "R7");
    send(1, 5, 0, 0, 20);
    send(3, 7, 0, 0, 21);
    drain();
    chk(wb_cyc[21] == wb_cyc[20] + 1, "R7 second writer next cycle", wb_cyc[21], wb_cyc[20] + 1);

    // R5 done on idle unit
    extra_done[2] = 1'b1;
    @(negedge clk);
    extra_done[2] = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(wb_valid == 1'b0, "R5 idle done ignored", int'(wb_valid), 0);
      @(negedge clk);
    end

    chk(q_tag.size() == 0, "R8 all results written", q_tag.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule